// File: doc/BRIEF.md
# BCH Error Position Applier

This block sits after a BCH decoder in a flash read path and turns the decoder's report for one sector into corrections in a byte-addressed sector buffer. After a start request it waits for the decoder to signal that its report is ready. It then takes in one status word and four position words. The status word carries the outcome flags and an error count. Each position word carries two bit positions. For every usable position, the block performs a read-modify-write on the buffer that inverts a single bit.

The block does not touch the buffer when the decoder found nothing or declared the sector beyond repair. It also leaves alone any position that lies past the data area, because such a position refers to the stored check bytes. The block runs in either a 4-bit or an 8-bit correction mode. When the report does not arrive within a fixed number of cycles, the block gives up. It ends every run with a one-cycle done pulse and a result code.

Top module: `bch_fix_applier`

## Requirements
- R1: While reset is asserted and after it is released, done_o, mem_re_o and mem_we_o are low and result_o reads 0 (ok).
- R2: After start_i is accepted, the block waits for dec_ready_i. If dec_ready_i is not seen on any of the TIMEOUT_CYC clock edges that follow the accepting edge, done_o rises right after the TIMEOUT_CYC-th of those edges, with result_o = 2 (timeout) and no memory access.
- R3: A dec_ready_i seen on the TIMEOUT_CYC-th edge after the accepting edge is still honoured, and the result is not a timeout.
- R4: When the errors-found flag (stat_i bit 1) is clear, the run ends with result 0 and no memory access, whatever the uncorrectable flag holds.
- R5: When bit 1 and the uncorrectable flag (stat_i bit 0) are both set, the run ends with result 1 (uncorrectable) and no memory access.
- R6: The error count is stat_i[7:4]. Position word j is pos_words_i[32j+31:32j]; error 2j sits at bits [12:0] of it and error 2j+1 at [28:16]. Only the first min(count, cap) errors are used, where cap is 8 with corr8_i = 1 and 4 with corr8_i = 0.
- R7: A used position p with p < 8*sect_bytes_i inverts bit p mod 8 of byte p div 8. A position at or above 8*sect_bytes_i is skipped without any memory access.
- R8: Positions are applied one at a time in ascending error order. Each correction drives mem_re_o for one cycle, then drives mem_we_o two cycles later to the same address, with data that differs from the byte read in exactly one bit. Several positions in one byte therefore compound, and a repeated position restores the original byte.
- R9: done_o is high for exactly one cycle per run, and result_o holds its value until the next run ends. start_i has no effect while a run is in progress.
- R10: With bit 1 set, bit 0 clear and a count of zero, the run ends with result 0 and no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin processing one sector report |
| corr8_i | input | 1 | 1 selects 8-bit correction, 0 selects 4-bit; sampled together with the report |
| dec_ready_i | input | 1 | Decoder report valid |
| stat_i | input | 32 | Status word: bit 0 uncorrectable, bit 1 errors found, [7:4] count |
| pos_words_i | input | 128 | Four position words, two 13-bit positions each |
| sect_bytes_i | input | 11 | Data area size in bytes |
| mem_addr_o | output | 10 | Buffer byte address |
| mem_re_o | output | 1 | Buffer read strobe; read data is valid the following cycle |
| mem_we_o | output | 1 | Buffer write strobe |
| mem_wdata_o | output | 8 | Buffer write data |
| mem_rdata_i | input | 8 | Buffer read data |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 ok, 1 uncorrectable, 2 timeout |

## Verification
The bench keeps the default 13-bit position width and eight positions, so a 1024-byte buffer model covers every byte a position can name, including the first position past a full 512-byte sector. It shrinks TIMEOUT_CYC to 20. With that value, both the exact expiry edge and a ready that arrives on the last allowed edge can be measured cycle by cycle. A 64-byte sector puts the data-area boundary in the middle of the position range, so that boundary can be exercised as well.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;

  localparam int UNCORR_BIT = 0;
  localparam int FOUND_BIT  = 1;
  localparam int CNT_LSB    = 4;
  localparam int CNT_W      = 4;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_UNCORR  = 2'd1,
    RES_TIMEOUT = 2'd2
  } fix_res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CHECK,
    ST_SCAN,
    ST_RD,
    ST_MOD,
    ST_WR,
    ST_DONE
  } fix_st_e;

endpackage

// File: rtl/bch_pos_unpack.sv
module bch_pos_unpack #(
  parameter int POS_W   = 13,
  parameter int NUM_POS = 8,
  parameter int SIZE_W  = 11
) (
  input  logic [32*(NUM_POS/2)-1:0]       words_i,
  input  logic [SIZE_W-1:0]               sect_i,
  output logic [NUM_POS-1:0][POS_W-1:0]   pos_o,
  output logic [NUM_POS-1:0]              inrng_o
);

  localparam int WORDS = NUM_POS / 2;
  localparam int PAD_W = 16 - POS_W;

  logic [WORDS-1:0] unused_pad;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign unused_pad[w] = ^{words_i[32*w+16+POS_W +: PAD_W],
                             words_i[32*w+POS_W +: PAD_W]};
  end

  for (genvar k = 0; k < NUM_POS; k++) begin : g_pos
    assign pos_o[k] = words_i[32*(k/2) + 16*(k%2) +: POS_W];
    // pos < 8*size  <=>  pos/8 < size
    assign inrng_o[k] = SIZE_W'(pos_o[k][POS_W-1:3]) < sect_i;
  end

endmodule

// File: rtl/bch_wait_timer.sv
module bch_wait_timer #(
  parameter int LIMIT = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (en_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/bch_fix_applier.sv
module bch_fix_applier
  import bch_fix_pkg::*;
#(
  parameter int POS_W       = 13,
  parameter int NUM_POS     = 8,
  parameter int TIMEOUT_CYC = 10000,
  localparam int ADDR_W = POS_W - 3,
  localparam int SIZE_W = ADDR_W + 1,
  localparam int PW_W   = 32 * (NUM_POS / 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              corr8_i,
  input  logic              dec_ready_i,
  input  logic [31:0]       stat_i,
  input  logic [PW_W-1:0]   pos_words_i,
  input  logic [SIZE_W-1:0] sect_bytes_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              done_o,
  output logic [1:0]        result_o
);

  localparam int IDX_W = $clog2(NUM_POS + 1);
  localparam int SEL_W = $clog2(NUM_POS);

  fix_st_e                   state_q;
  fix_res_e                  result_q;
  logic                      found_q, uncorr_q;
  logic [IDX_W-1:0]          limit_q, idx_q;
  logic [PW_W-1:0]           words_q;
  logic [SIZE_W-1:0]         sect_q;
  logic [ADDR_W-1:0]         addr_q;
  logic [2:0]                bit_q;
  logic [7:0]                wbuf_q;

  logic [NUM_POS-1:0][POS_W-1:0] pos_arr;
  logic [NUM_POS-1:0]            inrng;
  logic [POS_W-1:0]              pos_sel;
  logic                          inrng_sel;
  logic                          tmr_expired;
  logic [CNT_W-1:0]              cnt_raw;
  logic [IDX_W-1:0]              cap, limit_d;
  logic                          unused_stat;

  assign unused_stat = ^{stat_i[31:CNT_LSB+CNT_W], stat_i[CNT_LSB-1:FOUND_BIT+1]};

  bch_pos_unpack #(
    .POS_W  (POS_W),
    .NUM_POS(NUM_POS),
    .SIZE_W (SIZE_W)
  ) unpack_i (
    .words_i(words_q),
    .sect_i (sect_q),
    .pos_o  (pos_arr),
    .inrng_o(inrng)
  );

  bch_wait_timer #(
    .LIMIT(TIMEOUT_CYC)
  ) timer_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q == ST_IDLE),
    .en_i     (state_q == ST_WAIT),
    .expired_o(tmr_expired)
  );

  // count clamped to the mode's correction capacity
  assign cnt_raw = stat_i[CNT_LSB +: CNT_W];
  assign cap     = corr8_i ? IDX_W'(NUM_POS) : IDX_W'(NUM_POS / 2);
  assign limit_d = (int'(cnt_raw) > int'(cap)) ? cap : IDX_W'(cnt_raw);

  assign pos_sel   = pos_arr[idx_q[SEL_W-1:0]];
  assign inrng_sel = inrng[idx_q[SEL_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      result_q <= RES_OK;
      found_q  <= 1'b0;
      uncorr_q <= 1'b0;
      limit_q  <= '0;
      idx_q    <= '0;
      words_q  <= '0;
      sect_q   <= '0;
      addr_q   <= '0;
      bit_q    <= '0;
      wbuf_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (dec_ready_i) begin
            found_q  <= stat_i[FOUND_BIT];
            uncorr_q <= stat_i[UNCORR_BIT];
            limit_q  <= limit_d;
            words_q  <= pos_words_i;
            sect_q   <= sect_bytes_i;
            state_q  <= ST_CHECK;
          end else if (tmr_expired) begin
            result_q <= RES_TIMEOUT;
            state_q  <= ST_DONE;
          end
        end
        ST_CHECK: begin
          if (!found_q) begin
            result_q <= RES_OK;
            state_q  <= ST_DONE;
          end else if (uncorr_q) begin
            result_q <= RES_UNCORR;
            state_q  <= ST_DONE;
          end else begin
            idx_q   <= '0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (idx_q >= limit_q) begin
            result_q <= RES_OK;
            state_q  <= ST_DONE;
          end else if (inrng_sel) begin
            addr_q  <= pos_sel[POS_W-1:3];
            bit_q   <= pos_sel[2:0];
            state_q <= ST_RD;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_RD:  state_q <= ST_MOD;
        ST_MOD: begin
          wbuf_q  <= mem_rdata_i ^ (8'h01 << bit_q);
          state_q <= ST_WR;
        end
        ST_WR: begin
          idx_q   <= idx_q + 1'b1;
          state_q <= ST_SCAN;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_re_o    = (state_q == ST_RD);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_wdata_o = wbuf_q;
  assign done_o      = (state_q == ST_DONE);
  assign result_o    = result_q;

endmodule

// File: rtl/bch_fix_applier_chk.sv
module bch_fix_applier_chk #(
  parameter int POS_W = 13,
  localparam int ADDR_W = POS_W - 3,
  localparam int SIZE_W = ADDR_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_re_o,
  input logic              mem_we_o,
  input logic [7:0]        mem_wdata_o,
  input logic [7:0]        mem_rdata_i,
  input logic [SIZE_W-1:0] sect_bytes_i,
  input logic              done_o
);

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_wr_after_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_re_o, 2));

  p_quiet_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> (!mem_re_o && !mem_we_o));

  p_same_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == $past(mem_addr_o, 2)));

  p_one_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($countones(mem_wdata_o ^ $past(mem_rdata_i)) == 1));

  p_addr_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> (SIZE_W'(mem_addr_o) < sect_bytes_i));

  p_no_rw_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mem_re_o && !mem_we_o));

endmodule

bind bch_fix_applier bch_fix_applier_chk #(.POS_W(POS_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_addr_o  (mem_addr_o),
  .mem_re_o    (mem_re_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i),
  .sect_bytes_i(sect_bytes_i),
  .done_o      (done_o)
);

// File: tb/bch_fix_applier_tb_top.sv
module bch_fix_applier_tb_top;

  localparam int T_OUT = 20;
  localparam int MEMSZ = 1024;

  function automatic logic [31:0] pw(input int a, input int b);
    logic [12:0] la, lb;
    la = a[12:0];
    lb = b[12:0];
    return {3'd0, lb, 3'd0, la};
  endfunction

  typedef struct packed {
    logic         corr8;
    logic [10:0]  sect;
    logic [7:0]   st;
    logic [127:0] pws;
    logic [1:0]   res;
    logic [3:0]   wr;
  } vec_t;

  localparam int NV = 11;
  // stat byte: bit0 uncorrectable, bit1 found, [7:4] count
  localparam vec_t VT [NV] = '{
    '{1'b1, 11'd512, 8'h32, {pw(0,0),    pw(0,0),    pw(4095,0),  pw(5,100)},   2'd0, 4'd3}, // R7 last valid bit
    '{1'b1, 11'd512, 8'h22, {pw(0,0),    pw(0,0),    pw(0,0),     pw(4096,17)}, 2'd0, 4'd1}, // R7 first invalid
    '{1'b1, 11'd512, 8'h21, {pw(0,0),    pw(0,0),    pw(0,0),     pw(9,10)},    2'd0, 4'd0}, // R4
    '{1'b1, 11'd512, 8'h33, {pw(0,0),    pw(0,0),    pw(11,0),    pw(9,10)},    2'd1, 4'd0}, // R5
    '{1'b1, 11'd512, 8'h02, {pw(0,0),    pw(0,0),    pw(0,0),     pw(1,0)},     2'd0, 4'd0}, // R10
    '{1'b0, 11'd512, 8'h62, {pw(0,0),    pw(5,6),    pw(3,4),     pw(1,2)},     2'd0, 4'd4}, // R6 4-bit cap
    '{1'b1, 11'd512, 8'h82, {pw(3500,4000), pw(2500,3000), pw(1500,2000), pw(3,900)}, 2'd0, 4'd8}, // R6 R8
    '{1'b1, 11'd512, 8'h22, {pw(0,0),    pw(0,0),    pw(0,0),     pw(77,77)},   2'd0, 4'd2}, // R8 repeat
    '{1'b1, 11'd64,  8'h32, {pw(0,0),    pw(0,0),    pw(40,0),    pw(511,512)}, 2'd0, 4'd2}, // R7 small sector
    '{1'b1, 11'd512, 8'hF2, {pw(70,80),  pw(50,60),  pw(30,40),   pw(10,20)},   2'd0, 4'd8}, // R6 8-bit cap
    '{1'b0, 11'd512, 8'h42, {pw(0,0),    pw(0,0),    pw(200,300), pw(4,8000)},  2'd0, 4'd3}  // R6 R7
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         corr8_i = 1'b1;
  logic         dec_ready_i = 1'b0;
  logic [31:0]  stat_i = '0;
  logic [127:0] pos_words_i = '0;
  logic [10:0]  sect_bytes_i = 11'd512;
  logic [9:0]   mem_addr_o;
  logic         mem_re_o, mem_we_o, done_o;
  logic [7:0]   mem_wdata_o;
  logic [7:0]   mem_rdata_i = '0;
  logic [1:0]   result_o;

  int total = 0;
  int bad = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic init_mem = 1'b0;
  logic [7:0] mem [MEMSZ];
  logic [7:0] exp_mem [MEMSZ];

  always #5 clk = ~clk;

  bch_fix_applier #(.TIMEOUT_CYC(T_OUT)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .corr8_i     (corr8_i),
    .dec_ready_i (dec_ready_i),
    .stat_i      (stat_i),
    .pos_words_i (pos_words_i),
    .sect_bytes_i(sect_bytes_i),
    .mem_addr_o  (mem_addr_o),
    .mem_re_o    (mem_re_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .done_o      (done_o),
    .result_o    (result_o)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  always @(posedge clk) begin
    if (init_mem) begin
      for (int i = 0; i < MEMSZ; i++) mem[i] <= pat(i);
      wr_cnt <= 0;
      rd_cnt <= 0;
    end else begin
      if (mem_re_o) begin
        mem_rdata_i <= mem[mem_addr_o];
        rd_cnt <= rd_cnt + 1;
      end
      if (mem_we_o) begin
        mem[mem_addr_o] <= mem_wdata_o;
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    init_mem = 1'b1;
    @(negedge clk);
    init_mem = 1'b0;
    for (int i = 0; i < MEMSZ; i++) exp_mem[i] = pat(i);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done_o && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic mem_cmp(input string req);
    int mism;
    mism = 0;
    for (int i = 0; i < MEMSZ; i++) if (mem[i] !== exp_mem[i]) mism++;
    chk(mism == 0, req, mism, 0);
  endtask

  task automatic run_vec(input vec_t v, input int id);
    int n, lim, cap;
    logic [12:0] p;
    clear_mem();
    if (v.st[1] && !v.st[0]) begin
      cap = v.corr8 ? 8 : 4;
      lim = (int'(v.st[7:4]) > cap) ? cap : int'(v.st[7:4]);
      for (int k = 0; k < lim; k++) begin
        p = v.pws[32*(k/2) + 16*(k%2) +: 13];
        if (int'(p) < 8 * int'(v.sect)) exp_mem[p >> 3] ^= 8'(1 << (p & 7));
      end
    end
    corr8_i      = v.corr8;
    sect_bytes_i = v.sect;
    stat_i       = {24'd0, v.st};
    pos_words_i  = v.pws;
    start_i      = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    dec_ready_i = 1'b1;
    wait_done(n);
    dec_ready_i = 1'b0;
    chk(done_o, "R9 vector done seen", int'(done_o), 1);
    chk(result_o == v.res, $sformatf("R6 R7 vector %0d result", id), int'(result_o), int'(v.res));
    chk(wr_cnt == int'(v.wr), $sformatf("R7 R8 vector %0d writes", id), wr_cnt, int'(v.wr));
    mem_cmp($sformatf("R7 R8 vector %0d buffer mismatches", id));
    @(negedge clk);
    chk(!done_o, "R9 done one cycle", int'(done_o), 0);
    chk(result_o == v.res, "R9 result held", int'(result_o), int'(v.res));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!done_o && !mem_re_o && !mem_we_o, "R1 outputs in reset", int'({done_o, mem_re_o, mem_we_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(result_o == 2'd0 && !done_o, "R1 after release", int'(result_o), 0);

    for (int i = 0; i < NV; i++) run_vec(VT[i], i);

    // R2 timeout: ready never arrives
    clear_mem();
    stat_i = 32'h32;
    pos_words_i = {96'd0, pw(5, 6)};
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 1;
    while (!done_o && n < 500) begin
      @(negedge clk);
      n++;
    end
    // done after edge T_OUT past the start edge -> negedge index T_OUT+1
    chk(n == T_OUT + 1, "R2 timeout latency", n, T_OUT + 1);
    chk(result_o == 2'd2, "R2 timeout result", int'(result_o), 2);
    chk(wr_cnt == 0 && rd_cnt == 0, "R2 no access on timeout", wr_cnt + rd_cnt, 0);
    repeat (3) @(negedge clk);

    // R3 ready on the last allowed edge
    stat_i = 32'h33;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (T_OUT - 1) @(negedge clk);
    dec_ready_i = 1'b1;
    wait_done(n);
    dec_ready_i = 1'b0;
    chk(result_o == 2'd1, "R3 late ready honoured", int'(result_o), 1);
    repeat (3) @(negedge clk);

    // R9 start ignored while busy
    clear_mem();
    corr8_i = 1'b1;
    sect_bytes_i = 11'd512;
    stat_i = 32'h42;
    pos_words_i = {64'd0, pw(300, 301), pw(16, 17)};
    exp_mem[2] ^= 8'h01; exp_mem[2] ^= 8'h02;
    exp_mem[37] ^= 8'h10; exp_mem[37] ^= 8'h20;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    repeat (2) @(negedge clk);
    start_i = 1'b0;
    dec_ready_i = 1'b1;
    repeat (4) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(n);
    dec_ready_i = 1'b0;
    chk(wr_cnt == 4, "R9 busy run writes", wr_cnt, 4);
    mem_cmp("R8 same-byte compounding");
    begin
      int extra;
      extra = 0;
      @(negedge clk);
      for (int c = 0; c < 40; c++) begin
        if (done_o) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R9 no run from busy start", extra, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule